// File: doc/BRIEF.md
# LAPD Transmit Controller

This block turns one message held in a byte-addressed buffer into an HDLC-style serial frame on a data-link channel. Software loads the buffer, presents the octet count and pulses a start command. The controller then sends an opening flag, the message octets, a 16-bit frame check sequence and a closing flag. It inserts a zero after every run of five ones inside the message and check sequence. Whenever no frame is in progress it keeps the channel filled with flag octets.

The channel sets the bit rate. Each pulse on the bit-tick input moves exactly one bit out, and that bit appears on the serial output one clock later together with a valid strobe. A busy flag covers the whole frame. A sticky completion status bit clears when software reads the status. The interrupt line is that status bit gated by an enable bit.

Top module: `lapd_tx_ctrl`

## Requirements
- R1: While busy is 0, the serial stream carries back-to-back flag octets 0x7E. Every octet leaves least significant bit first. Each bit_tick high in a cycle produces exactly one bit on tx_bit, with tx_valid high in the following cycle. tx_valid is low in any cycle that does not follow a tick.
- R2: A start pulse is accepted when busy is 0 and msg_len is not 0. Busy then reads 1 from the next cycle. The frame sent is one opening flag, then msg_len octets read from buffer addresses 0 upward, then the check sequence, then one closing flag.
- R3: Inside the message octets and the check sequence, a 0 bit follows every five consecutive 1 bits. Flag octets are never stuffed.
- R4: The check sequence is the CRC over the message octets with generator x^16+x^12+x^5+1. It is processed least significant bit first with a preset of 0xFFFF, then complemented and sent low octet first.
- R5: Busy falls to 0 in the same cycle that the last bit of the closing flag appears on tx_bit.
- R6: A start pulse is ignored while busy is 1, and also when msg_len is 0. Neither case starts a frame or changes the length of the frame in progress.
- R7: irq_stat is set when a frame completes. It stays at 1 until a cycle with stat_rd high, and reads 0 from the clock after that read.
- R8: If a frame completes in the same cycle as a status read, irq_stat ends at 1, so the new completion is not lost.
- R9: irq equals irq_stat AND irq_en, as a level.
- R10: After reset, busy, irq_stat, irq and tx_valid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | Channel bit slot: shift one bit out this cycle |
| start | input | 1 | Start-of-message command pulse |
| msg_len | input | LEN_W | Message length in octets |
| buf_addr | output | ADDR_W | Message buffer read address |
| buf_data | input | 8 | Buffer octet at buf_addr (combinational read) |
| irq_en | input | 1 | Completion interrupt enable |
| stat_rd | input | 1 | Status register read strobe (clears irq_stat) |
| tx_bit | output | 1 | Serial output bit |
| tx_valid | output | 1 | tx_bit holds a new bit this cycle |
| busy | output | 1 | Frame in progress |
| irq_stat | output | 1 | Sticky completion status |
| irq | output | 1 | Level interrupt output |

## Verification
The bench aims at runs of ones that cross octet edges, including runs that cross from the last message octet into the check sequence and runs that end exactly at the last check bit. A design that got these wrong would either leave six ones inside the frame, so a false flag splits the frame, or stuff the closing flag. It also holds the status read high across the completion cycle. A design with read priority would lose the event and show irq_stat at 0 when busy falls. Start pulses are sent in the middle of a frame and with a zero length. A design that honoured them would restart, resize the frame or send an empty frame, and the bench decoder sees each of these as a length or content error.

// File: rtl/lapd_tx_pkg.sv
// Package: shared constants, frame state type and the CRC octet step.
// Assumes reflected (LSB-first) CRC processing as used on HDLC links.
package lapd_tx_pkg;

    localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
    localparam logic [15:0] CRC_POLY_R  = 16'h8408;  // x^16+x^12+x^5+1, bit-reversed
    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam int          STUFF_RUN   = 5;
    localparam int          ONES_W      = $clog2(STUFF_RUN + 1);
    localparam int          OCT_BITS    = 8;
    localparam int          BITCNT_W    = $clog2(OCT_BITS + 1);

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_OPEN,
        FS_BODY,
        FS_FCS_LO,
        FS_FCS_HI,
        FS_CLOSE,
        FS_TAIL
    } frm_state_t;

    // Advance the reflected CRC over one octet, least significant bit first.
    function automatic logic [15:0] crc_octet(input logic [15:0] c_in,
                                              input logic [7:0]  d);
        logic [15:0] c;
        c = c_in;
        for (int i = 0; i < OCT_BITS; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_R;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/lapd_crc16.sv
// Frame check accumulator: preset on init, advanced one octet per update.
// Assumes init and upd are never high together (the sequencer guarantees it).
module lapd_crc16
    import lapd_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    // Hold the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= CRC_PRESET;
        else if (init) crc <= CRC_PRESET;
        else if (upd)  crc <= crc_octet(crc, din);
    end

endmodule

// File: rtl/lapd_tx_seq.sv
// Frame sequencer: picks the octet the serializer loads next, and whether
// that octet is subject to zero insertion. It advances on each take pulse
// from the serializer. Assumes buf_data is valid in the cycle buf_addr shows.
module lapd_tx_seq
    import lapd_tx_pkg::*;
#(
    parameter int LEN_W  = 7,
    parameter int ADDR_W = 6
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  msg_len,
    input  logic              take,
    input  logic [15:0]       crc_val,
    input  logic [7:0]        buf_data,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        nxt_octet,
    output logic              nxt_stuff,
    output logic              busy,
    output logic              done,
    output logic              crc_init,
    output logic              crc_upd
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    frm_state_t       state;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx;
    logic             accept;

    assign accept   = start && (state == FS_IDLE) && (msg_len != '0);
    assign busy     = (state != FS_IDLE);
    assign done     = take && (state == FS_TAIL);
    assign crc_init = accept;
    assign crc_upd  = take && (state == FS_BODY);
    assign buf_addr = idx[ADDR_W-1:0];

    // Frame state, captured length and octet index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;
            len_q <= '0;
            idx   <= '0;
        end else if (accept) begin
            state <= FS_OPEN;
            len_q <= msg_len;
            idx   <= '0;
        end else if (take) begin
            unique case (state)
                FS_OPEN:   state <= FS_BODY;
                FS_BODY: begin
                    idx <= idx + LEN_ONE;
                    if (idx == len_q - LEN_ONE) state <= FS_FCS_LO;
                end
                FS_FCS_LO: state <= FS_FCS_HI;
                FS_FCS_HI: state <= FS_CLOSE;
                FS_CLOSE:  state <= FS_TAIL;
                FS_TAIL:   state <= FS_IDLE;
                default:   state <= FS_IDLE;
            endcase
        end
    end

    // Select the octet offered to the serializer.
    always_comb begin
        nxt_octet = FLAG_OCTET;
        nxt_stuff = 1'b0;
        unique case (state)
            FS_BODY:   begin nxt_octet = buf_data;       nxt_stuff = 1'b1; end
            FS_FCS_LO: begin nxt_octet = ~crc_val[7:0];  nxt_stuff = 1'b1; end
            FS_FCS_HI: begin nxt_octet = ~crc_val[15:8]; nxt_stuff = 1'b1; end
            default:   begin nxt_octet = FLAG_OCTET;     nxt_stuff = 1'b0; end
        endcase
    end

endmodule

// File: rtl/lapd_tx_ser.sv
// Bit serializer with zero insertion. Shifts the held octet out LSB first,
// one bit per tick, and inserts a 0 after five ones when the octet is stuffed.
// Raises take on the tick that frees the register, so the next octet loads
// with no gap. Assumes nxt_octet and nxt_stuff are valid whenever take is high.
module lapd_tx_ser
    import lapd_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic [7:0] nxt_octet,
    input  logic       nxt_stuff,
    output logic       take,
    output logic       tx_bit,
    output logic       tx_valid
);

    localparam logic [ONES_W-1:0]   RUN_MAX  = ONES_W'(STUFF_RUN);
    localparam logic [ONES_W-1:0]   RUN_PRE  = ONES_W'(STUFF_RUN - 1);
    localparam logic [BITCNT_W-1:0] CNT_FULL = BITCNT_W'(OCT_BITS);

    logic [7:0]          shreg;
    logic [BITCNT_W-1:0] cnt;
    logic [ONES_W-1:0]   ones;
    logic                stuff_q;
    logic                stuff_now;
    logic                cur;
    logic                run_hits;

    assign cur       = shreg[0];
    assign stuff_now = stuff_q && (ones == RUN_MAX);
    assign run_hits  = stuff_q && cur && (ones == RUN_PRE);
    assign take      = bit_tick && (stuff_now ? (cnt == '0)
                                              : ((cnt == BITCNT_W'(1)) && !run_hits));

    // Shift, count ones, insert zeros and reload from the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= FLAG_OCTET;
            cnt      <= CNT_FULL;
            ones     <= '0;
            stuff_q  <= 1'b0;
            tx_bit   <= 1'b0;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= bit_tick;
            if (bit_tick) begin
                if (stuff_now) begin
                    tx_bit <= 1'b0;
                    ones   <= '0;
                end else begin
                    tx_bit <= cur;
                    shreg  <= shreg >> 1;
                    cnt    <= cnt - BITCNT_W'(1);
                    ones   <= (stuff_q && cur) ? ones + ONES_W'(1) : '0;
                end
                if (take) begin
                    shreg   <= nxt_octet;
                    cnt     <= CNT_FULL;
                    stuff_q <= nxt_stuff;
                end
            end
        end
    end

endmodule

// File: rtl/lapd_tx_stat.sv
// Completion status: sticky bit set by the frame-done event, cleared by a
// status read, with the event winning a tie. The interrupt is a gated level.
module lapd_tx_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic stat_rd,
    input  logic irq_en,
    output logic irq_stat,
    output logic irq
);

    // Set on completion, clear on read, completion has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_stat <= 1'b0;
        else if (done)    irq_stat <= 1'b1;
        else if (stat_rd) irq_stat <= 1'b0;
    end

    assign irq = irq_stat & irq_en;

endmodule

// File: rtl/lapd_tx_ctrl.sv
// Top level: LAPD transmit controller. Joins the sequencer, serializer, CRC
// accumulator and status register. Assumes the message buffer answers
// buf_addr combinationally and is stable while busy is high.
module lapd_tx_ctrl
    import lapd_tx_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LEN_W  = ADDR_W + 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              start,
    input  logic [LEN_W-1:0]  msg_len,
    output logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_data,
    input  logic              irq_en,
    input  logic              stat_rd,
    output logic              tx_bit,
    output logic              tx_valid,
    output logic              busy,
    output logic              irq_stat,
    output logic              irq
);

    logic        take;
    logic [7:0]  nxt_octet;
    logic        nxt_stuff;
    logic        done;
    logic        crc_init;
    logic        crc_upd;
    logic [15:0] crc_val;

    lapd_tx_seq #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .msg_len   (msg_len),
        .take      (take),
        .crc_val   (crc_val),
        .buf_data  (buf_data),
        .buf_addr  (buf_addr),
        .nxt_octet (nxt_octet),
        .nxt_stuff (nxt_stuff),
        .busy      (busy),
        .done      (done),
        .crc_init  (crc_init),
        .crc_upd   (crc_upd)
    );

    lapd_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .upd   (crc_upd),
        .din   (nxt_octet),
        .crc   (crc_val)
    );

    lapd_tx_ser u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .nxt_octet (nxt_octet),
        .nxt_stuff (nxt_stuff),
        .take      (take),
        .tx_bit    (tx_bit),
        .tx_valid  (tx_valid)
    );

    lapd_tx_stat u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done),
        .stat_rd  (stat_rd),
        .irq_en   (irq_en),
        .irq_stat (irq_stat),
        .irq      (irq)
    );

endmodule

// File: rtl/lapd_tx_ctrl_chk.sv
// Checker: port-level properties of the transmit controller, bound to the top.
module lapd_tx_ctrl_chk #(
    parameter int LEN_W = 7
)(
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             start,
    input logic [LEN_W-1:0] msg_len,
    input logic             stat_rd,
    input logic             tx_bit,
    input logic             tx_valid,
    input logic             busy,
    input logic             irq_stat
);

    a_r1_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> tx_valid);

    a_r1_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> !tx_valid);

    a_r1_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(tx_bit));

    a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (msg_len != '0)) |=> busy);

    a_r6_zero_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (msg_len == '0)) |=> !busy);

    a_r6_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> busy);

    a_r5_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_tick));

    a_r7_set_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_stat) |-> $fell(busy));

    a_r7_clear_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_stat) |-> $past(stat_rd));

    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq_stat);

endmodule

bind lapd_tx_ctrl lapd_tx_ctrl_chk #(.LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .start    (start),
    .msg_len  (msg_len),
    .stat_rd  (stat_rd),
    .tx_bit   (tx_bit),
    .tx_valid (tx_valid),
    .busy     (busy),
    .irq_stat (irq_stat)
);

// File: tb/lapd_tx_ctrl_bench.sv
module lapd_tx_ctrl_bench;

    localparam int ADDR_W = 6;
    localparam int LEN_W  = ADDR_W + 1;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bit_tick = 1'b0;
    logic              start = 1'b0;
    logic [LEN_W-1:0]  msg_len = '0;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0]        buf_data;
    logic              irq_en = 1'b0;
    logic              stat_rd = 1'b0;
    logic              tx_bit, tx_valid, busy, irq_stat, irq;

    always #10 clk = ~clk;   // 50 MHz

    logic [7:0] mem [0:DEPTH-1];
    assign buf_data = mem[buf_addr];

    lapd_tx_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_lapd_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start),
        .msg_len(msg_len), .buf_addr(buf_addr), .buf_data(buf_data),
        .irq_en(irq_en), .stat_rd(stat_rd), .tx_bit(tx_bit),
        .tx_valid(tx_valid), .busy(busy), .irq_stat(irq_stat), .irq(irq)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected frame contents
    logic [7:0] exp_msg [0:DEPTH-1];
    int         exp_len = 0;
    bit         exp_armed = 1'b0;
    bit         exp_rd_hold = 1'b0;

    function automatic logic [15:0] ref_fcs(input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++)
            for (int i = 0; i < 8; i++) begin
                logic fb;
                fb = c[0] ^ exp_msg[k][i];
                c  = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        return ~c;
    endfunction

    function automatic int ref_stuffs(input int n);
        logic [15:0] f;
        int ones = 0, cnt = 0;
        logic [7:0] o;
        f = ref_fcs(n);
        for (int k = 0; k < n + 2; k++) begin
            o = (k < n) ? exp_msg[k] : ((k == n) ? f[7:0] : f[15:8]);
            for (int i = 0; i < 8; i++) begin
                if (o[i]) begin
                    ones++;
                    if (ones == 5) begin cnt++; ones = 0; end
                end else ones = 0;
            end
        end
        return cnt;
    endfunction

    // Receive-side decoder state
    logic [7:0] win = 8'h00;
    int  ones_run = 0;
    bit  dbit [0:2047];
    int  dbits = 0;
    int  stuffed = 0;
    int  frames_seen = 0;
    int  flags_seen = 0;
    bit  prev_busy = 1'b0;
    bit  last_tick = 1'b0;
    bit  tick_on = 1'b0;

    task automatic frame_end();
        int n, nb, bad;
        logic [15:0] f;
        logic [7:0] got;
        n = dbits - 7;
        if (n <= 0) begin
            flags_seen++;
            return;
        end
        frames_seen++;
        chk(exp_armed, "R6", "unexpected frame", 1, 0);
        chk(n % 8 == 0, "R2", "frame bit count mod 8", n % 8, 0);
        nb = n / 8;
        chk(nb == exp_len + 2, "R2", "frame octets", nb, exp_len + 2);
        bad = 0;
        for (int k = 0; k < exp_len && k < nb; k++) begin
            got = '0;
            for (int i = 0; i < 8; i++) got[i] = dbit[k*8+i];
            if (got != exp_msg[k]) bad++;
        end
        chk(bad == 0, "R2", "message octet mismatches", bad, 0);
        f = ref_fcs(exp_len);
        got = '0;
        for (int i = 0; i < 8; i++) got[i] = dbit[exp_len*8+i];
        chk(got == f[7:0], "R4", "fcs low octet", got, f[7:0]);
        got = '0;
        for (int i = 0; i < 8; i++) got[i] = dbit[exp_len*8+8+i];
        chk(got == f[15:8], "R4", "fcs high octet", got, f[15:8]);
        chk(stuffed == ref_stuffs(exp_len), "R3", "inserted zeros", stuffed, ref_stuffs(exp_len));
        chk(busy == 1'b0, "R5", "busy at last closing bit", busy, 0);
        chk(prev_busy == 1'b1, "R5", "busy at prior bit", prev_busy, 1);
        chk(irq_stat == 1'b1, exp_rd_hold ? "R8" : "R7", "status at completion", irq_stat, 1);
        exp_armed = 1'b0;
    endtask

    task automatic decode(input logic b);
        win = {b, win[7:1]};
        if (win == 8'h7E) begin
            frame_end();
            dbits = 0;
            stuffed = 0;
            ones_run = 0;
        end else if (b) begin
            ones_run++;
            if (ones_run == 7) chk(1'b0, "R3", "run of ones", ones_run, 5);
            if (dbits < 2048) dbit[dbits] = 1'b1;
            dbits++;
        end else begin
            if (ones_run == 5) stuffed++;
            else begin
                if (dbits < 2048) dbit[dbits] = 1'b0;
                dbits++;
            end
            ones_run = 0;
        end
    endtask

    // Bit-slot driver and serial monitor (R1)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (tx_valid != last_tick)
                    chk(1'b0, "R1", "tx_valid after tick", tx_valid, last_tick);
                if (tx_valid) begin
                    decode(tx_bit);
                    prev_busy = busy;
                end
            end
            bit_tick = tick_on && (($urandom % 4) != 0);
            last_tick = bit_tick;
        end
    end

    task automatic wait_frames(input int target);
        while (frames_seen < target) @(negedge clk);
    endtask

    task automatic wait_flags(input int cnt);
        int t;
        t = flags_seen + cnt;
        while (flags_seen < t) @(negedge clk);
    endtask

    task automatic run_frame(input int len, input bit en, input bit rd_hold,
                             input bit mid_start);
        int target;
        for (int k = 0; k < len; k++) exp_msg[k] = mem[k];
        exp_len = len;
        exp_armed = 1'b1;
        exp_rd_hold = rd_hold;
        target = frames_seen + 1;
        @(negedge clk);
        irq_en = en;
        stat_rd = rd_hold;
        start = 1'b1;
        msg_len = LEN_W'(len);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        if (mid_start) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            msg_len = LEN_W'(len + 3);
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R6", "busy after start while busy", busy, 1);
        end
        wait_frames(target);
        @(negedge clk);
        if (rd_hold) begin
            chk(irq_stat == 1'b0, "R8", "status cleared by held read", irq_stat, 0);
            stat_rd = 1'b0;
        end else begin
            chk(irq_stat == 1'b1, "R7", "status sticky", irq_stat, 1);
            chk(irq == en, "R9", "irq level", irq, en);
            repeat (3) @(negedge clk);
            chk(irq_stat == 1'b1, "R7", "status still sticky", irq_stat, 1);
            stat_rd = 1'b1;
            @(negedge clk);
            stat_rd = 1'b0;
            chk(irq_stat == 1'b0, "R7", "status cleared by read", irq_stat, 0);
            chk(irq == 1'b0, "R9", "irq after clear", irq, 0);
        end
        if (mid_start) begin
            wait_flags(3);
            chk(busy == 1'b0, "R6", "no restart after ignored start", busy, 0);
        end
    endtask

    task automatic fill(input int len, input int mode);
        for (int k = 0; k < len; k++) begin
            unique case (mode)
                0: mem[k] = 8'($urandom);
                1: mem[k] = 8'hFF;
                2: mem[k] = (k % 2 == 0) ? 8'hF8 : 8'h1F;
                3: mem[k] = 8'h7E;
                default: mem[k] = (($urandom % 2) == 0) ? 8'hFF : 8'($urandom);
            endcase
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Main sequence
    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < DEPTH; k++) mem[k] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R10", "busy after reset", busy, 0);
        chk(irq_stat == 1'b0, "R10", "irq_stat after reset", irq_stat, 0);
        chk(irq == 1'b0, "R10", "irq after reset", irq, 0);
        chk(tx_valid == 1'b0, "R10", "tx_valid after reset", tx_valid, 0);
        tick_on = 1'b1;
        wait_flags(4);
        chk(frames_seen == 0, "R1", "idle stream holds only flags", frames_seen, 0);

        // Directed corner cases
        fill(1, 0);  run_frame(1, 1'b1, 1'b0, 1'b0);
        fill(8, 1);  run_frame(8, 1'b0, 1'b0, 1'b0);
        fill(9, 2);  run_frame(9, 1'b1, 1'b1, 1'b0);
        fill(6, 3);  run_frame(6, 1'b1, 1'b0, 1'b1);
        fill(DEPTH, 4); run_frame(DEPTH, 1'b1, 1'b0, 1'b0);

        // Zero-length start is ignored (R6)
        @(negedge clk);
        start = 1'b1;
        msg_len = '0;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R6", "zero length start", busy, 0);
        begin
            int f0;
            f0 = frames_seen;
            wait_flags(3);
            chk(frames_seen == f0, "R6", "no frame from zero length", frames_seen, f0);
        end

        // Random frames
        for (int t = 0; t < 14; t++) begin
            int len;
            len = 1 + int'($urandom % 24);
            fill(len, int'($urandom % 5));
            run_frame(len, 1'($urandom), 1'($urandom), (t % 5) == 2);
            wait_flags(1 + int'($urandom % 2));
        end
        chk(busy == 1'b0, "R1", "idle at end", busy, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule